// File: doc/BRIEF.md
# Sample Output Formatter with Forwarded Clock

This block takes a stream of 8-bit converter samples, each with an over-range flag, and places them on one or two output data buses together with a forwarded data clock. A 16-bit control word selects the output scheme: double data rate, with a word presented on both edges of the forwarded clock, or single data rate, with a word presented on one chosen edge. In double data rate the samples are either sent one by one on a single bus, or gathered in pairs and sent on two buses at once. In the paired case the forwarded clock is either edge-aligned or centre-aligned with the data. An auxiliary output carries either the over-range flag or a second copy of the forwarded clock.

All timing comes from one internal clock. The forwarded clock is a register that toggles on that clock, so a centre-aligned clock is offset by one internal cycle from the data transitions. The control word may be written only while the initialization enable is high. Any accepted write restarts the output sequencer: the forwarded clock goes low, the pair phase returns to its first slot and a half-gathered pair is discarded. The data outputs keep their values across the restart.

Samples enter on a valid/ready interface. A sample transfers on a rising clock edge where both `smp_valid` and `smp_ready` are high. `smp_ready` depends only on the block's state and the control word, never on `smp_valid`. The source may hold `smp_valid` low at any time. The formatter then keeps the last word on the bus and the forwarded clock keeps its cadence.

Top module: `smp_out_fmt`

## Requirements
- R1: After reset the control word reads 0xB2FF, the forwarded clock, both data buses and the auxiliary output are 0, and `smp_ready` is 1.
- R2: A write strobe while `init_en` is low leaves the control word unchanged and does not disturb the forwarded clock or the data outputs.
- R3: A write with `init_en` high stores the written value with bit 15 forced to 1, bit 14 forced to 0 and bits 7:0 forced to 1. For example, 0x7B00 reads back as 0xBBFF and 0x0000 reads back as 0x80FF.
- R4: With bit 10 = 0 and bit 8 = 1 (double rate, single bus), `smp_ready` stays 1 and each accepted sample appears on `data_a` one cycle later. The forwarded clock toggles every cycle on the same edge, and bit 11 has no effect.
- R5: With bits 10, 8 and 11 all 0 (double rate, paired, edge-aligned), two consecutive samples appear together, the first on `data_a` and the second on `data_b`. A pair can load only every second cycle, and the forwarded clock toggles on exactly those edges.
- R6: With bit 10 = 0, bit 8 = 0 and bit 11 = 1 (double rate, paired, centre-aligned), the loading is the same as in R5, but the forwarded clock toggles one cycle after each pair slot and never on the edge where a pair loads.
- R7: With bit 10 = 1 (single rate), the forwarded clock toggles every cycle, and `data_a` changes only on the edge where the forwarded clock becomes equal to bit 8: 1 selects the rising edge and 0 the falling edge. `smp_ready` is high only in the cycle before such an edge.
- R8: In paired mode, `smp_ready` is low exactly while a first sample is held and the next cycle is not a pair slot. In single-bus double rate it is always high.
- R9: A cycle without a transfer leaves the data buses and the over-range flag unchanged, while the forwarded clock keeps its cadence.
- R10: The over-range flag is registered with its word (in paired mode it is the OR of both flags). The flag is driven on `aux_o` when bit 13 = 1, and `aux_o` is a copy of `dclk_o` when bit 13 = 0.
- R11: An accepted write drives `dclk_o` to 0 and discards a half-gathered pair, so the next two samples form the next pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock that drives all output timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_en | input | 1 | Allows control-word writes while high |
| cfg_we | input | 1 | Control-word write strobe |
| cfg_wdata | input | 16 | Control-word write data |
| cfg_word | output | 16 | Current control word |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Formatter accepts a sample this cycle |
| smp_data | input | 8 | Sample value |
| smp_ovr | input | 1 | Over-range flag of the sample |
| dclk_o | output | 1 | Forwarded data clock |
| aux_o | output | 1 | Over-range flag, or a second forwarded clock |
| data_a_o | output | 8 | Data bus A (single bus, or first sample of a pair) |
| data_b_o | output | 8 | Data bus B (second sample of a pair) |

## Verification
Several properties are checked on every cycle, for any stimulus:
- the control word stays frozen outside accepted writes;
- the forwarded clock toggles every cycle in single-bus double rate;
- in paired mode, the data buses change only together with the forwarded clock (edge-aligned) or only while it holds (centre-aligned);
- in single-rate mode, the data changes only on the selected clock level.

Other behaviours only the bench scenarios can show:
- that the right samples reach the right bus in the right order;
- that a discarded half-pair after a restart shifts the pairing;
- that `smp_ready` follows the back-pressure rule;
- that the auxiliary output switches between the flag and the clock copy;
- that the forced bits read back correctly.

// File: rtl/smp_fmt_pkg.sv
package smp_fmt_pkg;
  localparam int SMP_W = 8;
  localparam int CFG_W = 16;
  // Two output lanes: the pairing logic holds exactly one staged sample.
  localparam int NLANE = 2;

  // Control word bit positions (the decoder depends on them)
  localparam int B_HI1     = 15;  // forced 1
  localparam int B_HI0     = 14;  // forced 0
  localparam int B_DCLK2_N = 13;  // 0: aux output is a clock copy
  localparam int B_QUAD    = 11;  // centre-aligned clock in paired mode
  localparam int B_SDR     = 10;  // 1: single data rate
  localparam int B_EDGE    = 8;   // SDR edge select / DDR pairing select
  localparam int B_LOW_MSB = 7;   // bits 7:0 forced 1

  localparam logic [CFG_W-1:0] CFG_RST = 16'hB2FF;

  typedef enum logic [1:0] {
    FM_DDR_DMX  = 2'd0,
    FM_DDR_PASS = 2'd1,
    FM_SDR      = 2'd2
  } fmt_mode_e;

  typedef struct packed {
    fmt_mode_e mode;
    logic      quad;
    logic      rise;
    logic      dual_clk;
  } fmt_ctl_t;
endpackage

// File: rtl/smp_fmt_cfg.sv
module smp_fmt_cfg
  import smp_fmt_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_en,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] word_q,
  output logic         restart
);
  logic [W-1:0] forced;

  assign restart = we & init_en;

  always_comb begin
    forced              = wdata;
    forced[B_HI1]       = 1'b1;
    forced[B_HI0]       = 1'b0;
    forced[B_LOW_MSB:0] = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= CFG_RST[W-1:0];
    end else if (restart) begin
      word_q <= forced;
    end
  end

  // R2: word only moves on an enabled write
  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> $stable(word_q));
endmodule

// File: rtl/smp_fmt_dec.sv
module smp_fmt_dec
  import smp_fmt_pkg::*;
(
  input  logic     sdr_bit,
  input  logic     edge_bit,
  input  logic     quad_bit,
  input  logic     dclk2_n_bit,
  output fmt_ctl_t ctl
);
  always_comb begin
    ctl.dual_clk = ~dclk2_n_bit;
    ctl.rise     = 1'b0;
    ctl.quad     = 1'b0;
    if (sdr_bit) begin
      // edge bit selects the data transition edge
      ctl.mode = FM_SDR;
      ctl.rise = edge_bit;
    end else if (edge_bit) begin
      // single-bus double rate: phase forced to edge-aligned
      ctl.mode = FM_DDR_PASS;
    end else begin
      ctl.mode = FM_DDR_DMX;
      ctl.quad = quad_bit;
    end
  end
endmodule

// File: rtl/smp_fmt_lane.sv
module smp_fmt_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (ld) begin
      q <= d;
    end
  end
endmodule

// File: rtl/smp_fmt_seq.sv
module smp_fmt_seq
  import smp_fmt_pkg::*;
#(
  parameter int W  = SMP_W,
  parameter int NL = NLANE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  fmt_ctl_t             ctl,
  input  logic                 s_valid,
  input  logic [W-1:0]         s_data,
  input  logic                 s_ovr,
  output logic                 s_ready,
  output logic                 dclk_q,
  output logic                 ovr_q,
  output logic [NL-1:0][W-1:0] lane_q
);
  logic         ph_q;
  logic         stv_q;
  logic [W-1:0] st_q;
  logic         sto_q;
  logic         acc;
  logic         is_dmx;
  logic         pair_ld;
  logic         stash_ld;
  logic         word_ld;
  logic         dclk_nxt;
  logic [NL-1:0]        lane_ld;
  logic [NL-1:0][W-1:0] lane_d;

  assign is_dmx = (ctl.mode == FM_DDR_DMX);

  // Back-pressure: fixed cadence per mode
  always_comb begin
    case (ctl.mode)
      FM_SDR:      s_ready = ((~dclk_q) == ctl.rise);
      FM_DDR_PASS: s_ready = 1'b1;
      default:     s_ready = ~stv_q | ph_q;
    endcase
  end

  assign acc      = s_valid & s_ready & ~restart;
  assign pair_ld  = is_dmx & acc & stv_q & ph_q;
  assign stash_ld = is_dmx & acc & ~(stv_q & ph_q);
  assign word_ld  = (~is_dmx & acc) | pair_ld;

  // Forwarded clock cadence
  always_comb begin
    if (restart) begin
      dclk_nxt = 1'b0;
    end else if (is_dmx) begin
      dclk_nxt = (ph_q != ctl.quad) ? ~dclk_q : dclk_q;
    end else begin
      dclk_nxt = ~dclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_q <= 1'b0;
      ph_q   <= 1'b0;
      stv_q  <= 1'b0;
      st_q   <= '0;
      sto_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      dclk_q <= dclk_nxt;
      ph_q   <= restart ? 1'b0 : ~ph_q;
      if (restart) begin
        stv_q <= 1'b0;
      end else if (stash_ld) begin
        stv_q <= 1'b1;
        st_q  <= s_data;
        sto_q <= s_ovr;
      end else if (pair_ld) begin
        stv_q <= 1'b0;
      end
      if (word_ld) begin
        ovr_q <= is_dmx ? (sto_q | s_ovr) : s_ovr;
      end
    end
  end

  // Output lanes: lane 0 takes the staged sample in paired mode
  for (genvar g = 0; g < NL; g++) begin : g_lane
    if (g == 0) begin : g_first
      assign lane_ld[g] = word_ld;
      assign lane_d[g]  = is_dmx ? st_q : s_data;
    end else begin : g_rest
      assign lane_ld[g] = pair_ld;
      assign lane_d[g]  = s_data;
    end
    smp_fmt_lane #(.W(W)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .ld   (lane_ld[g]),
      .d    (lane_d[g]),
      .q    (lane_q[g])
    );
  end

  // R4: single-bus double rate toggles the clock every cycle
  p_pass_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.mode == FM_DDR_PASS && !restart) |=> (dclk_q != $past(dclk_q)));

  // R5: edge-aligned pairs change together with the clock
  p_dmx_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dmx && !ctl.quad && !$past(restart) && !$stable(lane_q[0]))
      |-> !$stable(dclk_q));

  // R6: centre-aligned pairs change while the clock holds
  p_dmx_centre_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dmx && ctl.quad && !$past(restart) && !$stable(lane_q[0]))
      |-> $stable(dclk_q));

  // R7: single-rate data moves only on the selected clock level
  p_sdr_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.mode == FM_SDR && !$past(restart) && !$stable(lane_q[0]))
      |-> (dclk_q == ctl.rise));
endmodule

// File: rtl/smp_out_fmt.sv
module smp_out_fmt
  import smp_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_en,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_word,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              smp_ovr,
  output logic              dclk_o,
  output logic              aux_o,
  output logic [SMP_W-1:0]  data_a_o,
  output logic [SMP_W-1:0]  data_b_o
);
  logic                       restart;
  fmt_ctl_t                   ctl;
  logic                       ovr_q;
  logic [NLANE-1:0][SMP_W-1:0] lanes;

  smp_fmt_cfg #(.W(CFG_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .init_en(init_en),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .word_q (cfg_word),
    .restart(restart)
  );

  smp_fmt_dec u_dec (
    .sdr_bit    (cfg_word[B_SDR]),
    .edge_bit   (cfg_word[B_EDGE]),
    .quad_bit   (cfg_word[B_QUAD]),
    .dclk2_n_bit(cfg_word[B_DCLK2_N]),
    .ctl        (ctl)
  );

  smp_fmt_seq #(.W(SMP_W), .NL(NLANE)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(restart),
    .ctl    (ctl),
    .s_valid(smp_valid),
    .s_data (smp_data),
    .s_ovr  (smp_ovr),
    .s_ready(smp_ready),
    .dclk_q (dclk_o),
    .ovr_q  (ovr_q),
    .lane_q (lanes)
  );

  assign data_a_o = lanes[0];
  assign data_b_o = lanes[1];
  assign aux_o    = ctl.dual_clk ? dclk_o : ovr_q;
endmodule

// File: tb/test_smp_out_fmt.sv
`timescale 1ns/1ps
module test_smp_out_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_word;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [7:0]  smp_data = '0;
  logic        smp_ovr = 1'b0;
  logic        dclk_o;
  logic        aux_o;
  logic [7:0]  data_a_o;
  logic [7:0]  data_b_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  int seq_n = 0;

  // Reference state derived from the requirements
  logic [15:0] m_cfg = 16'hB2FF;
  logic m_dclk = 0, m_ph = 0, m_stv = 0, m_sto = 0, m_or = 0;
  logic [7:0] m_st = 0, m_a = 0, m_b = 0;

  // {write data, expected read-back}
  localparam logic [31:0] VEC [0:6] = '{
    32'hB2FF_B2FF,   // paired, edge-aligned, flag on aux
    32'hBAFF_BAFF,   // paired, centre-aligned
    32'h7B00_BBFF,   // single bus, phase bit ignored, forced bits
    32'hB7FF_B7FF,   // single rate, rising edge
    32'hB6FF_B6FF,   // single rate, falling edge
    32'h93FF_93FF,   // single bus, clock copy on aux
    32'h0000_80FF    // paired, clock copy, forced bits
  };

  always #2 clk = ~clk;

  smp_out_fmt i_smp_out_fmt (
    .clk(clk), .rst_n(rst_n), .init_en(init_en), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_word(cfg_word), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .smp_ovr(smp_ovr),
    .dclk_o(dclk_o), .aux_o(aux_o), .data_a_o(data_a_o), .data_b_o(data_b_o)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp,
                     input string tag, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string mtag();
    if (m_cfg[10]) return "R7";
    else if (m_cfg[8]) return "R4";
    else if (m_cfg[11]) return "R6";
    else return "R5";
  endfunction

  function automatic logic mready();
    if (m_cfg[10]) return (~m_dclk) == m_cfg[8];
    else if (m_cfg[8]) return 1'b1;
    else return ~m_stv | m_ph;
  endfunction

  task automatic mstep(input logic acc, input logic [7:0] d, input logic o,
                       input logic rs, input logic [15:0] wd);
    if (rs) begin
      m_cfg = {1'b1, 1'b0, wd[13:8], 8'hFF};
      m_dclk = 0; m_ph = 0; m_stv = 0;
    end else if (m_cfg[10] || m_cfg[8]) begin
      m_dclk = ~m_dclk;
      if (acc) begin m_a = d; m_or = o; end
      m_ph = ~m_ph;
    end else begin
      if (m_ph != m_cfg[11]) m_dclk = ~m_dclk;
      if (acc) begin
        if (m_stv && m_ph) begin
          m_a = m_st; m_b = d; m_or = m_sto | o; m_stv = 0;
        end else begin
          m_st = d; m_sto = o; m_stv = 1;
        end
      end
      m_ph = ~m_ph;
    end
  endtask

  // Check outputs at this falling edge, drive inputs, advance one cycle
  task automatic cyc(input logic v, input logic [7:0] d, input logic o,
                     input logic we, input logic ie, input logic [15:0] wd);
    logic r;
    chk({15'd0, dclk_o}, {15'd0, m_dclk}, mtag(), "dclk");
    chk({8'd0, data_a_o}, {8'd0, m_a}, mtag(), "data_a");
    chk({8'd0, data_b_o}, {8'd0, m_b}, mtag(), "data_b");
    chk({15'd0, aux_o}, {15'd0, (m_cfg[13] ? m_or : m_dclk)}, "R10", "aux");
    r = mready();
    chk({15'd0, smp_ready}, {15'd0, r}, "R8", "ready");
    smp_valid = v; smp_data = d; smp_ovr = o;
    cfg_we = we; init_en = ie; cfg_wdata = wd;
    mstep(v && r && !(we && ie), d, o, we && ie, wd);
    @(negedge clk);
  endtask

  task automatic stream(input int n);
    for (int k = 0; k < n; k++) begin
      cyc((k % 5) != 3, 8'(seq_n + 8'h30), (seq_n % 3) == 0, 1'b0, 1'b0, 16'h0);
      seq_n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(cfg_word, 16'hB2FF, "R1", "cfg_word");
    chk({15'd0, dclk_o}, 16'd0, "R1", "dclk");
    chk({8'd0, data_a_o}, 16'd0, "R1", "data_a");
    chk({8'd0, data_b_o}, 16'd0, "R1", "data_b");
    chk({15'd0, aux_o}, 16'd0, "R1", "aux");
    chk({15'd0, smp_ready}, 16'd1, "R1", "ready");
    stream(6);

    // Table of modes, one loop
    for (int i = 0; i < 7; i++) begin
      cyc(1'b0, 8'h0, 1'b0, 1'b1, 1'b1, VEC[i][31:16]);
      chk(cfg_word, VEC[i][15:0], "R3", "readback");
      chk({15'd0, dclk_o}, 16'd0, "R11", "dclk after write");
      stream(24);
    end

    // R2: write without init enable is ignored
    begin
      logic [15:0] keep;
      keep = cfg_word;
      cyc(1'b0, 8'h0, 1'b0, 1'b1, 1'b0, 16'hB7FF);
      chk(cfg_word, keep, "R2", "cfg_word");
      stream(8);
    end

    // R9: hold during gaps, single bus
    cyc(1'b0, 8'h0, 1'b0, 1'b1, 1'b1, 16'hBBFF);
    cyc(1'b1, 8'hA5, 1'b1, 1'b0, 1'b0, 16'h0);
    for (int k = 0; k < 3; k++) begin
      chk({8'd0, data_a_o}, 16'h00A5, "R9", "held data");
      cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 16'h0);
    end

    // R11: restart discards a half-gathered pair
    cyc(1'b0, 8'h0, 1'b0, 1'b1, 1'b1, 16'hB2FF);
    cyc(1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 16'h0);
    cyc(1'b0, 8'h0, 1'b0, 1'b1, 1'b1, 16'hB2FF);
    cyc(1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 16'h0);
    cyc(1'b1, 8'h33, 1'b1, 1'b0, 1'b0, 16'h0);
    chk({8'd0, data_a_o}, 16'h0022, "R11", "pair first");
    chk({8'd0, data_b_o}, 16'h0033, "R11", "pair second");
    chk({15'd0, aux_o}, 16'd1, "R10", "pair flag");
    cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 16'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule